// File: doc/BRIEF.md
# Dual-Polarisation Jones-Corrected Phase Beamformer

This block forms a single beam from a stream of station samples. Each cycle may carry one sample for one station. A sample holds a complex value for each of the two polarisations, with signed 8-bit real and imaginary parts. The block first multiplies the polarisation pair by a 2x2 complex correction matrix kept for that station. The station weight is already folded into this matrix. It then rotates both polarisations by a per-station phase, given as cosine and sine terms. Finally it adds the result of every station of one channel/time into a pair of wide complex accumulators.

The sample stream enters with three flags. A first-station flag starts a new sum and a last-station flag closes it. A flag that marks interference removes that one sample from the sum. A copy of the input, with all its flags, is passed on one cycle later so the next beam instance in a chain sees the same data. The coefficient tables are loaded through a simple write port, one 16-bit word per write.

Top module: `jones_beamformer`

## Requirements
- R1: After reset the outputs fwd_valid and beam_valid are low and all four beam outputs are zero. Every coefficient word is zero, so a sample sent before any table write adds zero to the beam.
- R2: fwd_valid, fwd_station, fwd_first, fwd_last, fwd_rfi and the four fwd sample fields equal the corresponding inputs of the previous clock cycle, without any modification.
- R3: The polarisation pair (X, Y) is replaced by (J00·X + J01·Y, J10·X + J11·Y) using complex products. Each result part is then divided by 2^14 and rounded toward minus infinity.
- R4: The matrix output P becomes P·(c + j·s), where c and s are the station's cosine and sine words. Each result part is again divided by 2^14 and rounded toward minus infinity. c = 16384, s = 0 leaves P unchanged.
- R5: beam_x and beam_y are the 32-bit sums of the rotated results of every sample from the one carrying in_first up to the one carrying in_last. Earlier sums are not carried over.
- R6: A station whose eight matrix words are all zero adds nothing to the beam, whatever its phase words.
- R7: A sample presented with in_rfi high adds zero to the beam. It is still counted for the first/last framing.
- R8: beam_valid pulses for one cycle exactly 3 rising edges after the edge that captures a sample with in_last high. It does not pulse at any other time. Between pulses the beam outputs hold their value.
- R9: cfg_addr is {station, word}, with the word in the low 4 bits. Words 0..7 hold J00 re, J00 im, J01 re, J01 im, J10 re, J10 im, J11 re, J11 im. Word 8 holds the cosine and word 9 the sine. Writes to words 10..15 change nothing.
- R10: A sample carrying both in_first and in_last forms a beam from that station alone. A new first flag restarts the sum even on the very next cycle after a last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_station | input | SW | Station index of the sample |
| in_first | input | 1 | First station of a channel/time |
| in_last | input | 1 | Last station of a channel/time |
| in_rfi | input | 1 | Sample corrupted by interference |
| in_xr | input | DW | X polarisation, real |
| in_xi | input | DW | X polarisation, imaginary |
| in_yr | input | DW | Y polarisation, real |
| in_yi | input | DW | Y polarisation, imaginary |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | SW+4 | Station and word index |
| cfg_data | input | CW | Coefficient word, Q1.14 |
| fwd_valid | output | 1 | Forwarded valid |
| fwd_station | output | SW | Forwarded station index |
| fwd_first | output | 1 | Forwarded first flag |
| fwd_last | output | 1 | Forwarded last flag |
| fwd_rfi | output | 1 | Forwarded interference flag |
| fwd_xr | output | DW | Forwarded X real |
| fwd_xi | output | DW | Forwarded X imaginary |
| fwd_yr | output | DW | Forwarded Y real |
| fwd_yi | output | DW | Forwarded Y imaginary |
| beam_valid | output | 1 | Beam sum ready |
| beam_xr | output | AW | Beam X real |
| beam_xi | output | AW | Beam X imaginary |
| beam_yr | output | AW | Beam Y real |
| beam_yi | output | AW | Beam Y imaginary |

## Verification
A wrong coefficient word, a swapped matrix term or a misdecoded table address changes the very next beam that includes that station. It shows up 3 cycles after that channel's last sample. A first flag that is lost or stale leaves an earlier sum mixed into the next beam, so the fault appears at the following beam_valid pulse. A fault in the valid or last flag pipeline moves or drops a beam_valid pulse. Any change on the forward path shows one cycle later at the fwd outputs.

// File: rtl/jones_beamformer.sv
module jones_beamformer #(
  parameter int NSTA = 8,
  parameter int DW   = 8,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = 32,
  localparam int SW  = $clog2(NSTA),
  localparam int AB  = SW + 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SW-1:0]        in_station,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic                 in_rfi,
  input  logic signed [DW-1:0] in_xr,
  input  logic signed [DW-1:0] in_xi,
  input  logic signed [DW-1:0] in_yr,
  input  logic signed [DW-1:0] in_yi,
  input  logic                 cfg_we,
  input  logic [AB-1:0]        cfg_addr,
  input  logic [CW-1:0]        cfg_data,
  output logic                 fwd_valid,
  output logic [SW-1:0]        fwd_station,
  output logic                 fwd_first,
  output logic                 fwd_last,
  output logic                 fwd_rfi,
  output logic signed [DW-1:0] fwd_xr,
  output logic signed [DW-1:0] fwd_xi,
  output logic signed [DW-1:0] fwd_yr,
  output logic signed [DW-1:0] fwd_yi,
  output logic                 beam_valid,
  output logic signed [AW-1:0] beam_xr,
  output logic signed [AW-1:0] beam_xi,
  output logic signed [AW-1:0] beam_yr,
  output logic signed [AW-1:0] beam_yi
);
  localparam int NW = 10;
  localparam int PW = DW + CW;
  localparam int MW = PW + 2;
  localparam int QW = MW - FRAC;
  localparam int RW = QW + CW + 1;

  logic signed [CW-1:0] tab [NSTA][NW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int s = 0; s < NSTA; s++)
        for (int w = 0; w < NW; w++) tab[s][w] <= '0;
    end else if (cfg_we && cfg_addr[3:0] < 4'(NW))
      tab[cfg_addr[AB-1:4]][cfg_addr[3:0]] <= cfg_data;

  function automatic logic signed [MW-1:0] cm(input logic signed [DW-1:0] a,
                                              input logic signed [CW-1:0] b);
    logic signed [PW-1:0] p;
    p = PW'(a) * PW'(b);
    return MW'(p);
  endfunction

  function automatic logic signed [RW-1:0] rm(input logic signed [QW-1:0] a,
                                              input logic signed [CW-1:0] b);
    return RW'(a) * RW'(b);
  endfunction

  logic signed [CW-1:0] j [8];
  always_comb for (int k = 0; k < 8; k++) j[k] = tab[in_station][k];

  wire signed [MW-1:0] sxr = cm(in_xr, j[0]) - cm(in_xi, j[1]) + cm(in_yr, j[2]) - cm(in_yi, j[3]);
  wire signed [MW-1:0] sxi = cm(in_xi, j[0]) + cm(in_xr, j[1]) + cm(in_yi, j[2]) + cm(in_yr, j[3]);
  wire signed [MW-1:0] syr = cm(in_xr, j[4]) - cm(in_xi, j[5]) + cm(in_yr, j[6]) - cm(in_yi, j[7]);
  wire signed [MW-1:0] syi = cm(in_xi, j[4]) + cm(in_xr, j[5]) + cm(in_yi, j[6]) + cm(in_yr, j[7]);

  logic                 m_valid, m_first, m_last, m_rfi;
  logic [SW-1:0]        m_sta;
  logic signed [QW-1:0] m_xr, m_xi, m_yr, m_yi;
  logic                 r_valid, r_first, r_last;
  logic signed [AW-1:0] r_xr, r_xi, r_yr, r_yi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fwd_valid <= 1'b0; fwd_station <= '0; fwd_first <= 1'b0; fwd_last <= 1'b0; fwd_rfi <= 1'b0;
      fwd_xr <= '0; fwd_xi <= '0; fwd_yr <= '0; fwd_yi <= '0;
    end else begin
      fwd_valid <= in_valid; fwd_station <= in_station; fwd_first <= in_first;
      fwd_last <= in_last; fwd_rfi <= in_rfi;
      fwd_xr <= in_xr; fwd_xi <= in_xi; fwd_yr <= in_yr; fwd_yi <= in_yi;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_valid <= 1'b0; m_first <= 1'b0; m_last <= 1'b0; m_rfi <= 1'b0; m_sta <= '0;
      m_xr <= '0; m_xi <= '0; m_yr <= '0; m_yi <= '0;
    end else begin
      m_valid <= in_valid; m_first <= in_first; m_last <= in_last;
      m_rfi <= in_rfi; m_sta <= in_station;
      m_xr <= QW'(sxr >>> FRAC); m_xi <= QW'(sxi >>> FRAC);
      m_yr <= QW'(syr >>> FRAC); m_yi <= QW'(syi >>> FRAC);
    end

  wire signed [CW-1:0] pc = tab[m_sta][8];
  wire signed [CW-1:0] ps = tab[m_sta][9];
  wire signed [RW-1:0] qxr = rm(m_xr, pc) - rm(m_xi, ps);
  wire signed [RW-1:0] qxi = rm(m_xr, ps) + rm(m_xi, pc);
  wire signed [RW-1:0] qyr = rm(m_yr, pc) - rm(m_yi, ps);
  wire signed [RW-1:0] qyi = rm(m_yr, ps) + rm(m_yi, pc);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_valid <= 1'b0; r_first <= 1'b0; r_last <= 1'b0;
      r_xr <= '0; r_xi <= '0; r_yr <= '0; r_yi <= '0;
    end else begin
      r_valid <= m_valid; r_first <= m_first; r_last <= m_last;
      r_xr <= m_rfi ? '0 : AW'(qxr >>> FRAC);
      r_xi <= m_rfi ? '0 : AW'(qxi >>> FRAC);
      r_yr <= m_rfi ? '0 : AW'(qyr >>> FRAC);
      r_yi <= m_rfi ? '0 : AW'(qyi >>> FRAC);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      beam_valid <= 1'b0;
      beam_xr <= '0; beam_xi <= '0; beam_yr <= '0; beam_yi <= '0;
    end else begin
      beam_valid <= r_valid && r_last;
      if (r_valid) begin
        beam_xr <= r_first ? r_xr : beam_xr + r_xr;
        beam_xi <= r_first ? r_xi : beam_xi + r_xi;
        beam_yr <= r_first ? r_yr : beam_yr + r_yr;
        beam_yi <= r_first ? r_yi : beam_yi + r_yi;
      end
    end

  wire solo = in_valid && in_first && in_last;
  wire zero_mat = (j[0] == 0) && (j[1] == 0) && (j[2] == 0) && (j[3] == 0) &&
                  (j[4] == 0) && (j[5] == 0) && (j[6] == 0) && (j[7] == 0);

  assert_beam_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beam_valid |-> $past(in_valid && in_last, 3));

  assert_beam_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !r_valid |=> $stable(beam_xr) && $stable(beam_yi));

  assert_rfi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    solo && in_rfi |-> ##3 (beam_xr == 0 && beam_xi == 0 && beam_yr == 0 && beam_yi == 0));

  assert_zero_matrix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    solo && zero_mat |-> ##3 (beam_xr == 0 && beam_xi == 0 && beam_yr == 0 && beam_yi == 0));
endmodule

// File: tb/jones_beamformer_test.sv
module jones_beamformer_test;
  localparam int NSTA = 8, DW = 8, CW = 16, AW = 32, SW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, in_rfi = 0;
  logic [SW-1:0] in_station = 0;
  logic signed [DW-1:0] in_xr = 0, in_xi = 0, in_yr = 0, in_yi = 0;
  logic cfg_we = 0;
  logic [SW+3:0] cfg_addr = 0;
  logic [CW-1:0] cfg_data = 0;
  logic fwd_valid, fwd_first, fwd_last, fwd_rfi, beam_valid;
  logic [SW-1:0] fwd_station;
  logic signed [DW-1:0] fwd_xr, fwd_xi, fwd_yr, fwd_yi;
  logic signed [AW-1:0] beam_xr, beam_xi, beam_yr, beam_yi;

  jones_beamformer uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  longint bc [NSTA][10];
  longint ax, axi, ay, ayi;
  int     due_q [$];
  longint e_q [$];
  string  tag_q [$];
  string  cur_tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // forward path monitor (R2)
  logic p_v, p_f, p_l, p_r, fchk = 0;
  logic [SW-1:0] p_s;
  logic signed [DW-1:0] p_xr, p_xi, p_yr, p_yi;
  always @(posedge clk) begin
    p_v <= in_valid; p_f <= in_first; p_l <= in_last; p_r <= in_rfi; p_s <= in_station;
    p_xr <= in_xr; p_xi <= in_xi; p_yr <= in_yr; p_yi <= in_yi;
    fchk <= rst_n;
  end
  always @(negedge clk) if (fchk && rst_n) begin
    check("R2 fwd_valid", fwd_valid, p_v);
    if (p_v) begin
      check("R2 fwd flags", {fwd_first, fwd_last, fwd_rfi, fwd_station},
            {p_f, p_l, p_r, p_s});
      check("R2 fwd data", {fwd_xr, fwd_xi, fwd_yr, fwd_yi}, {p_xr, p_xi, p_yr, p_yi});
    end
  end

  // beam monitor (R8 timing, values by scenario tag)
  always @(negedge clk) if (rst_n && beam_valid) begin
    if (due_q.size() == 0) check("R8 unexpected beam_valid", 1, 0);
    else begin
      string t;
      t = tag_q.pop_front();
      check({t, " R8 beam cycle"}, cyc, due_q.pop_front());
      check({t, " beam_xr"}, beam_xr, e_q.pop_front());
      check({t, " beam_xi"}, beam_xi, e_q.pop_front());
      check({t, " beam_yr"}, beam_yr, e_q.pop_front());
      check({t, " beam_yi"}, beam_yi, e_q.pop_front());
    end
  end

  task automatic cfg(int st, int w, longint v);
    @(negedge clk);
    in_valid = 0;
    cfg_we = 1; cfg_addr = {3'(st), 4'(w)}; cfg_data = 16'(v);
    if (w < 10) bc[st][w] = longint'($signed(16'(v)));
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_sta(int st, longint a0, a1, a2, a3, a4, a5, a6, a7, c, s);
    cfg(st, 0, a0); cfg(st, 1, a1); cfg(st, 2, a2); cfg(st, 3, a3);
    cfg(st, 4, a4); cfg(st, 5, a5); cfg(st, 6, a6); cfg(st, 7, a7);
    cfg(st, 8, c);  cfg(st, 9, s);
  endtask

  function automatic longint fl(longint v);
    return v >>> 14;
  endfunction

  // R3 matrix, R4 rotation, R5 sum, R7 rfi
  task automatic send(int st, bit f, bit l, bit rfi, int xr, int xi, int yr, int yi);
    longint j0r, j0i, j1r, j1i, j2r, j2i, j3r, j3i, c, s;
    longint mxr, mxi, myr, myi, rxr, rxi, ryr, ryi;
    @(negedge clk);
    in_valid = 1; in_station = 3'(st); in_first = f; in_last = l; in_rfi = rfi;
    in_xr = 8'(xr); in_xi = 8'(xi); in_yr = 8'(yr); in_yi = 8'(yi);
    j0r = bc[st][0]; j0i = bc[st][1]; j1r = bc[st][2]; j1i = bc[st][3];
    j2r = bc[st][4]; j2i = bc[st][5]; j3r = bc[st][6]; j3i = bc[st][7];
    c = bc[st][8]; s = bc[st][9];
    mxr = fl(j0r*xr - j0i*xi + j1r*yr - j1i*yi);
    mxi = fl(j0r*xi + j0i*xr + j1r*yi + j1i*yr);
    myr = fl(j2r*xr - j2i*xi + j3r*yr - j3i*yi);
    myi = fl(j2r*xi + j2i*xr + j3r*yi + j3i*yr);
    rxr = fl(mxr*c - mxi*s); rxi = fl(mxr*s + mxi*c);
    ryr = fl(myr*c - myi*s); ryi = fl(myr*s + myi*c);
    if (rfi) begin rxr = 0; rxi = 0; ryr = 0; ryi = 0; end
    if (f) begin ax = rxr; axi = rxi; ay = ryr; ayi = ryi; end
    else begin ax += rxr; axi += rxi; ay += ryr; ayi += ryi; end
    if (l) begin
      due_q.push_back(cyc + 3);
      e_q.push_back(longint'($signed(32'(ax))));  e_q.push_back(longint'($signed(32'(axi))));
      e_q.push_back(longint'($signed(32'(ay))));  e_q.push_back(longint'($signed(32'(ayi))));
      tag_q.push_back(cur_tag);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0; in_rfi = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cur_tag = "R1";
    check("R1 fwd_valid in reset", fwd_valid, 0);
    check("R1 beam_valid in reset", beam_valid, 0);
    check("R1 beam in reset", {beam_xr, beam_xi, beam_yr, beam_yi}, 0);
    rst_n = 1;
    send(2, 1, 1, 0, 100, -50, 7, 127);
    idle(5);
  endtask

  task automatic t_identity;
    cur_tag = "R3 R4 identity";
    set_sta(0, 16384, 0, 0, 0, 0, 0, 16384, 0, 16384, 0);
    send(0, 1, 1, 0, 17, -128, 127, -3);
    idle(5);
  endtask

  task automatic t_matrix_sum;
    cur_tag = "R3 R5 mixed matrix";
    set_sta(1, 12000, -3000, 5000, 8000, -7000, 2500, 16383, -16384, 16384, 0);
    set_sta(3, -32768, 32767, -32768, -32768, 1, -1, 999, 20000, 11585, 11585);
    send(0, 1, 0, 0, 5, 6, -7, 8);
    send(1, 0, 0, 0, -128, -128, -128, -128);
    send(3, 0, 1, 0, 127, -128, 100, -99);
    idle(5);
  endtask

  task automatic t_rotation;
    cur_tag = "R4 quarter turn";
    set_sta(4, 16384, 0, 0, 0, 0, 0, 16384, 0, 0, 16384);
    send(4, 1, 1, 0, 40, -30, -20, 10);
    cur_tag = "R4 negative angle";
    set_sta(5, 16384, 0, 0, 0, 0, 0, 16384, 0, 11585, -11585);
    send(5, 1, 1, 0, 3, 1, -1, -3);
    idle(5);
  endtask

  task automatic t_zero_matrix;
    cur_tag = "R6 zero matrix";
    set_sta(6, 0, 0, 0, 0, 0, 0, 0, 0, 16384, 9000);
    send(6, 1, 1, 0, 127, 127, -128, -128);
    send(0, 1, 0, 0, 9, 9, 9, 9);
    send(6, 0, 1, 0, -100, 50, 77, -1);
    idle(5);
  endtask

  task automatic t_rfi;
    cur_tag = "R7 rfi sample";
    send(1, 1, 0, 0, 20, 30, 40, 50);
    send(3, 0, 0, 1, 127, 127, 127, 127);
    send(0, 0, 1, 0, -9, 8, -7, 6);
    cur_tag = "R7 rfi only";
    send(3, 1, 1, 1, 127, -128, 5, 5);
    idle(5);
  endtask

  task automatic t_back_to_back;
    cur_tag = "R10 single station";
    send(1, 1, 1, 0, 11, 22, 33, 44);
    cur_tag = "R10 restart";
    send(0, 1, 0, 0, 1, 2, 3, 4);
    send(3, 0, 1, 0, 5, 6, 7, 8);
    cur_tag = "R10 next channel";
    send(4, 1, 1, 0, -1, -2, -3, -4);
    idle(5);
  endtask

  task automatic t_gaps;
    cur_tag = "R8 gaps hold";
    send(0, 1, 0, 0, 60, 61, 62, 63);
    idle(3);
    check("R8 no beam in gap", beam_valid, 0);
    send(1, 0, 1, 0, -60, 12, 0, -1);
    idle(8);
    check("R8 beam holds", beam_xr, e_q.size() == 0 ? longint'($signed(32'(ax))) : -1);
  endtask

  task automatic t_cfg_ignore;
    cfg(1, 10, 16'h7fff);
    cfg(1, 12, 16'h8000);
    cfg(1, 15, 16'h1234);
    cur_tag = "R9 spare words ignored";
    send(1, 1, 1, 0, 50, -50, 25, -25);
    cur_tag = "R9 station slots separate";
    send(3, 1, 1, 0, 50, -50, 25, -25);
    idle(5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_identity();
    t_matrix_sum();
    t_rotation();
    t_zero_matrix();
    t_rfi();
    t_back_to_back();
    t_gaps();
    t_cfg_ignore();
    check("R8 all beams seen", due_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule